// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller with Per-Line Trigger Select

This block gathers eight interrupt request lines into one interrupt output for a processor. Software sets it up through a byte-wide write port. Each write carries a two-bit address that selects one of three targets:

- the command address,
- the data address,
- the trigger-select register.

A command write with bit 4 set starts an initialization sequence. The data writes that follow give the vector base and then, depending on the first word, a cascade word and an extra option word. After that sequence, a data write sets the mask register. Command writes with bit 4 clear carry end-of-interrupt and rotation commands.

Each request line is edge or level triggered according to its own bit in the trigger-select register. The level-trigger flag in the first initialization word does nothing. Lines that serve legacy edge-signalling devices are set to edge, and shared lines are set to level.

The controller keeps three registers: request, in-service and mask. Priority is fixed by default and can be made rotating. When the processor pulses the acknowledge input, the controller returns a vector made of the programmed base and the number of the winning line.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, all of these are zero: int_out, vec_valid, vec_out, the mask, in-service, request and trigger-select registers, the rotation flag and the priority pointer. With the pointer at zero, line 0 has the highest priority and every line is edge triggered.
- R2: A write to address 0 with data bit 4 set starts initialization. It clears the mask and in-service registers, returns priority to fixed order with line 0 highest, and turns rotation off. int_out stays low until the sequence completes. Requests still latch during initialization.
- R3: In the first word, bit 1 = 0 means a third word (any value) follows the base word at address 1. Bit 0 = 1 means a final option word (any value) follows after that. Bits 7:5, 3 and 2 of the first word are ignored, and so are the contents of the third and option words. Examples: 0x11 needs three data writes, 0x13 needs two, and 0x1A needs one.
- R4: An edge-mode line (its trigger bit is 0) latches a request on a 0-to-1 input change. The request stays set after the input falls, until that line is acknowledged.
- R5: A level-mode line (its trigger bit is 1) requests while its input is high. Its request drops one cycle after the input goes low.
- R6: A write to address 2 loads the trigger-select register, where bit i = 1 makes line i level triggered. This register alone decides the trigger mode, and initialization does not change it.
- R7: An acknowledge pulse while int_out is high does four things on the next cycle: it raises vec_valid for one cycle, sets vec_out to {base word bits 7:3, winning line number}, sets that line's in-service bit and clears its request.
- R8: With fixed priority, lower line numbers win. int_out is high only when an unmasked request exists whose priority is strictly above every in-service line.
- R9: Once initialization is complete, a write to address 1 loads the mask register (bit i = 1 masks line i). A masked line cannot raise int_out, but its edge request is still latched and is served after unmasking.
- R10: Command 0x20 (bits 7:5 = 001, bits 4:3 = 0) clears only the highest-priority in-service bit.
- R11: Command 0x80 turns rotation on and command 0x00 turns it off. With rotation on, each 0x20 end-of-interrupt makes the cleared line the lowest priority. Command 0xA0 clears the highest-priority in-service bit and makes that line lowest priority even when rotation is off.
- R12: An acknowledge while int_out is low returns vec_out = {base, 3'b111} with vec_valid high, and changes no request or in-service bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 command, 1 data, 2 trigger select |
| wr_data | input | 8 | Write data |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Interrupt to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | 8 | Interrupt vector |

## Verification
Each result has a fixed latency, counted from the clock edge that samples the stimulus:
- A change on irq_in reaches the request register at that first edge, so int_out reflects it one cycle later.
- A register write takes effect at the edge that samples it, so int_out reflects a write one cycle later.
- vec_out and vec_valid appear one cycle after the edge that samples ack.

The bench drives all inputs at the falling edge and samples all outputs at the falling edge that follows the capturing rising edge. It also compares int_out, vec_valid and vec_out against a behavioural model on every cycle.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BASE  = 2'd1,
    ST_CASC  = 2'd2,
    ST_EXTRA = 2'd3
  } seq_state_t;

  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_TRIG = 2'd2;

  localparam int START_BIT  = 4;
  localparam int SEL_BIT    = 3;
  localparam int NEED4_BIT  = 0;
  localparam int SINGLE_BIT = 1;

  localparam logic [2:0] OP_EOI     = 3'b001;
  localparam logic [2:0] OP_EOI_ROT = 3'b101;
  localparam logic [2:0] OP_ROT_ON  = 3'b100;
  localparam logic [2:0] OP_ROT_OFF = 3'b000;
endpackage

// File: rtl/pic_init_seq.sv
`timescale 1ns/1ps
module pic_init_seq
  import pic_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic                   ready,
  output logic [DATA_W-ID_W-1:0] vec_base,
  output logic                   init_go,
  output logic                   mask_we,
  output logic                   op_eoi,
  output logic                   op_rotate,
  output logic                   op_rot_on,
  output logic                   op_rot_off
);
  seq_state_t st_q, st_n;
  logic need4_q, single_q;
  logic cmd_wr, dat_wr, op_wr;
  logic [2:0] op_code;
  logic spare_unused;

  assign cmd_wr  = wr_en && (wr_addr == A_CMD);
  assign dat_wr  = wr_en && (wr_addr == A_DATA);
  assign ready   = (st_q == ST_RUN);
  assign init_go = cmd_wr && wr_data[START_BIT];
  assign op_wr   = cmd_wr && !wr_data[START_BIT] && !wr_data[SEL_BIT] && ready;
  assign op_code = wr_data[DATA_W-1 -: 3];
  assign spare_unused = ^wr_data;

  assign op_eoi     = op_wr && ((op_code == OP_EOI) || (op_code == OP_EOI_ROT));
  assign op_rotate  = op_wr && (op_code == OP_EOI_ROT);
  assign op_rot_on  = op_wr && (op_code == OP_ROT_ON);
  assign op_rot_off = op_wr && (op_code == OP_ROT_OFF);
  assign mask_we    = dat_wr && ready;

  function automatic seq_state_t after_base(input logic single, input logic need4);
    if (!single) return ST_CASC;
    return need4 ? ST_EXTRA : ST_RUN;
  endfunction

  always_comb begin
    st_n = st_q;
    if (init_go) begin
      st_n = ST_BASE;
    end else if (dat_wr) begin
      case (st_q)
        ST_BASE:  st_n = after_base(single_q, need4_q);
        ST_CASC:  st_n = need4_q ? ST_EXTRA : ST_RUN;
        ST_EXTRA: st_n = ST_RUN;
        default:  st_n = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      need4_q  <= 1'b0;
      single_q <= 1'b0;
      vec_base <= '0;
    end else begin
      st_q <= st_n;
      if (init_go) begin
        need4_q  <= wr_data[NEED4_BIT];
        single_q <= wr_data[SINGLE_BIT];
      end
      if (dat_wr && (st_q == ST_BASE)) vec_base <= wr_data[DATA_W-1:ID_W];
    end
  end

  // R2
  init_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |=> !ready);
  // R3
  extra_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !init_go && (st_q == ST_EXTRA)) |=> ready);
endmodule

// File: rtl/pic_trigger.sv
`timescale 1ns/1ps
module pic_trigger #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic prev_q, req_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        req_q  <= 1'b0;
      end else begin
        prev_q <= irq[g];
        if (lvl[g]) req_q <= irq[g] & ~clr[g];
        else        req_q <= (req_q & ~clr[g]) | (irq[g] & ~prev_q);
      end
    end
    assign req[g] = req_q;

    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lvl[g]) |-> (req[g] == ($past(irq[g]) && !$past(clr[g]))));
    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!lvl[g]) && $past(req[g]) && !$past(clr[g])) |-> req[g]);
  end
endmodule

// File: rtl/pic_prio.sv
`timescale 1ns/1ps
module pic_prio #(
  parameter int N    = 8,
  parameter int ID_W = 3
) (
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    mask,
  input  logic [N-1:0]    isr,
  input  logic [ID_W-1:0] hi,
  output logic            int_req,
  output logic [ID_W-1:0] win_id,
  output logic            svc_valid,
  output logic [ID_W-1:0] svc_id
);
  function automatic logic [ID_W-1:0] rank(input logic [ID_W-1:0] line,
                                           input logic [ID_W-1:0] top);
    return line - top;
  endfunction

  function automatic logic [ID_W:0] pick(input logic [N-1:0] v,
                                         input logic [ID_W-1:0] top);
    logic found;
    logic [ID_W-1:0] sel, idx;
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < N; k++) begin
      idx = top + ID_W'(k);
      if (v[idx] && !found) begin
        found = 1'b1;
        sel   = idx;
      end
    end
    return {found, sel};
  endfunction

  logic win_found;

  always_comb begin
    {win_found, win_id} = pick(req & ~mask, hi);
    {svc_valid, svc_id} = pick(isr, hi);
    int_req = win_found && (!svc_valid || (rank(win_id, hi) < rank(svc_id, hi)));
  end
endmodule

// File: rtl/pic8_ctrl.sv
`timescale 1ns/1ps
module pic8_ctrl #(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               ack,
  output logic               int_out,
  output logic               vec_valid,
  output logic [DATA_W-1:0]  vec_out
);
  localparam int ID_W   = $clog2(N_LINES);
  localparam int BASE_W = DATA_W - ID_W;
  localparam logic [N_LINES-1:0] ONE_HOT0 = {{(N_LINES-1){1'b0}}, 1'b1};

  logic [N_LINES-1:0] mask_q, isr_q, lvl_q, req, grant_hot, done_hot;
  logic [ID_W-1:0]    hi_q, win_id, svc_id;
  logic [BASE_W-1:0]  vec_base;
  logic rot_q, int_req, svc_valid, seq_ready, init_go, mask_we;
  logic op_eoi, op_rotate, op_rot_on, op_rot_off, ack_hit, trig_we;

  pic_init_seq #(.DATA_W(DATA_W), .ID_W(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ready(seq_ready), .vec_base(vec_base), .init_go(init_go), .mask_we(mask_we),
    .op_eoi(op_eoi), .op_rotate(op_rotate), .op_rot_on(op_rot_on), .op_rot_off(op_rot_off)
  );

  pic_trigger #(.N(N_LINES)) u_trig (
    .clk(clk), .rst_n(rst_n), .irq(irq_in), .lvl(lvl_q), .clr(grant_hot), .req(req)
  );

  pic_prio #(.N(N_LINES), .ID_W(ID_W)) u_prio (
    .req(req), .mask(mask_q), .isr(isr_q), .hi(hi_q),
    .int_req(int_req), .win_id(win_id), .svc_valid(svc_valid), .svc_id(svc_id)
  );

  assign int_out   = seq_ready && int_req;
  assign ack_hit   = ack && int_out;
  assign trig_we   = wr_en && (wr_addr == pic_pkg::A_TRIG);
  assign grant_hot = ack_hit ? (ONE_HOT0 << win_id) : '0;
  assign done_hot  = (op_eoi && svc_valid) ? (ONE_HOT0 << svc_id) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      isr_q     <= '0;
      lvl_q     <= '0;
      hi_q      <= '0;
      rot_q     <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      vec_valid <= ack;
      if (ack) vec_out <= {vec_base, ack_hit ? win_id : {ID_W{1'b1}}};
      if (trig_we) lvl_q <= wr_data[N_LINES-1:0];
      if (init_go) begin
        mask_q <= '0;
        isr_q  <= '0;
        hi_q   <= '0;
        rot_q  <= 1'b0;
      end else begin
        if (mask_we) mask_q <= wr_data[N_LINES-1:0];
        isr_q <= (isr_q | grant_hot) & ~done_hot;
        if (op_rot_on)  rot_q <= 1'b1;
        if (op_rot_off) rot_q <= 1'b0;
        if (op_eoi && svc_valid && (rot_q || op_rotate)) hi_q <= svc_id + 1'b1;
      end
    end
  end

  // R2
  int_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> seq_ready);
  // R7
  isr_rise_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_q & ~$past(isr_q)) != '0) |-> $past(ack && int_out));
  // R10
  eoi_single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_eoi) |-> ($countones($past(isr_q) & ~isr_q) <= 1));
  // R12
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack) && !$past(int_out)) |-> (vec_valid && (vec_out[ID_W-1:0] == {ID_W{1'b1}})));
endmodule

// File: tb/pic8_ctrl_bench.sv
`timescale 1ns/1ps
module pic8_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] irq_in = 8'd0;
  logic ack = 1'b0;
  logic int_out, vec_valid;
  logic [7:0] vec_out;

  always #2.5 clk = ~clk;

  pic8_ctrl u_pic8_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_in(irq_in), .ack(ack), .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference state
  logic [7:0] m_req = 0, m_prev = 0, m_mask = 0, m_isr = 0, m_lvl = 0, m_vec = 0;
  int m_hi = 0, m_state = 0, m_base = 0;
  bit m_rot = 0, m_need4 = 0, m_single = 0, m_vv = 0;

  function automatic int rk(int line);
    return (line - m_hi + 8) % 8;
  endfunction

  function automatic int best(logic [7:0] v);
    int b;
    b = -1;
    for (int i = 0; i < 8; i++)
      if (v[i] && (b < 0 || rk(i) < rk(b))) b = i;
    return b;
  endfunction

  function automatic bit m_int();
    int w, s;
    if (m_state != 0) return 0;
    w = best(m_req & ~m_mask);
    s = best(m_isr);
    if (w < 0) return 0;
    return (s < 0) || (rk(w) < rk(s));
  endfunction

  always @(posedge clk) begin
    int w, s;
    bit hit;
    logic [7:0] clr;
    if (!rst_n) begin
      m_req = 0; m_prev = 0; m_mask = 0; m_isr = 0; m_lvl = 0; m_vec = 0;
      m_hi = 0; m_state = 0; m_base = 0; m_rot = 0; m_need4 = 0; m_single = 0; m_vv = 0;
    end else begin
      hit = ack && m_int();
      w = best(m_req & ~m_mask);
      s = best(m_isr);
      clr = 0;
      m_vv = ack;
      if (ack) begin
        if (hit) begin
          m_vec = 8'(m_base * 8 + w);
          clr[w] = 1'b1;
        end else m_vec = 8'(m_base * 8 + 7);
      end
      for (int i = 0; i < 8; i++) begin
        if (m_lvl[i]) m_req[i] = irq_in[i] && !clr[i];
        else          m_req[i] = (m_req[i] && !clr[i]) || (irq_in[i] && !m_prev[i]);
      end
      m_prev = irq_in;
      if (hit) m_isr[w] = 1'b1;
      if (wr_en) begin
        if (wr_addr == 2'd2) m_lvl = wr_data;
        else if (wr_addr == 2'd0) begin
          if (wr_data[4]) begin
            m_state = 1; m_need4 = wr_data[0]; m_single = wr_data[1];
            m_mask = 0; m_isr = 0; m_hi = 0; m_rot = 0;
          end else if (m_state == 0 && !wr_data[3]) begin
            case (wr_data[7:5])
              3'b001, 3'b101: if (s >= 0) begin
                m_isr[s] = 1'b0;
                if (m_rot || wr_data[7]) m_hi = (s + 1) % 8;
              end
              3'b100: m_rot = 1;
              3'b000: m_rot = 0;
              default: ;
            endcase
          end
        end else if (wr_addr == 2'd1) begin
          case (m_state)
            0: m_mask = wr_data;
            1: begin
              m_base = int'(wr_data[7:3]);
              m_state = !m_single ? 2 : (m_need4 ? 3 : 0);
            end
            2: m_state = m_need4 ? 3 : 0;
            default: m_state = 0;
          endcase
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R8 int_out vs model", {7'd0, int_out}, {7'd0, m_int()});
      chk("R7 vec_valid vs model", {7'd0, vec_valid}, {7'd0, m_vv});
      if (m_vv) chk("R7 vec_out vs model", vec_out, m_vec);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] lines);
    @(negedge clk);
    irq_in = irq_in | lines;
    @(negedge clk);
    irq_in = irq_in & ~lines;
  endtask

  task automatic do_ack(input string tag, input logic [7:0] exp);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk({tag, " vec_valid"}, {7'd0, vec_valid}, 8'd1);
    chk({tag, " vec_out"}, vec_out, exp);
  endtask

  task automatic eoi();
    wr(2'd0, 8'h20);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 int_out after reset", {7'd0, int_out}, 8'd0);
    chk("R1 vec_valid after reset", {7'd0, vec_valid}, 8'd0);
    chk("R1 vec_out after reset", vec_out, 8'd0);

    // R2/R3: 0x11 needs base, third and option word
    wr(2'd0, 8'h11);
    chk("R2 int low after start", {7'd0, int_out}, 8'd0);
    pulse(8'h08);
    chk("R2 int held low during init", {7'd0, int_out}, 8'd0);
    wr(2'd1, 8'h40);
    chk("R3 waiting third word", {7'd0, int_out}, 8'd0);
    wr(2'd1, 8'h04);
    chk("R3 waiting option word", {7'd0, int_out}, 8'd0);
    wr(2'd1, 8'h01);
    chk("R3 ready after option word", {7'd0, int_out}, 8'd1);
    do_ack("R7 line3", 8'h43);
    chk("R8 blocked by own service", {7'd0, int_out}, 8'd0);
    eoi();
    chk("R10 eoi leaves nothing", {7'd0, int_out}, 8'd0);

    // R4 edge latch held after input falls
    pulse(8'h20);
    repeat (3) @(negedge clk);
    chk("R4 edge request held", {7'd0, int_out}, 8'd1);
    do_ack("R4 line5", 8'h45);
    eoi();

    // R5/R6 level line 2
    wr(2'd2, 8'h04);
    pulse(8'h04);
    chk("R5 level request while high", {7'd0, int_out}, 8'd1);
    @(negedge clk);
    chk("R6 level line drops after low", {7'd0, int_out}, 8'd0);

    // R8 fixed priority
    pulse(8'h42);
    do_ack("R8 line1 beats line6", 8'h41);
    chk("R8 lower line blocked", {7'd0, int_out}, 8'd0);
    pulse(8'h01);
    chk("R8 higher line preempts", {7'd0, int_out}, 8'd1);
    do_ack("R8 line0", 8'h40);
    eoi();
    chk("R10 only top bit cleared", {7'd0, int_out}, 8'd0);
    eoi();
    chk("R10 second eoi frees line6", {7'd0, int_out}, 8'd1);
    do_ack("R8 line6", 8'h46);
    eoi();

    // R9 mask
    wr(2'd1, 8'h80);
    pulse(8'h80);
    repeat (2) @(negedge clk);
    chk("R9 masked line silent", {7'd0, int_out}, 8'd0);
    wr(2'd1, 8'h00);
    chk("R9 latched after unmask", {7'd0, int_out}, 8'd1);
    do_ack("R9 line7", 8'h47);
    eoi();

    // R12 spurious
    do_ack("R12 spurious", 8'h47);
    chk("R12 no state change", {7'd0, int_out}, 8'd0);
    pulse(8'h10);
    do_ack("R12 later service", 8'h44);
    eoi();

    // R11 rotation
    wr(2'd0, 8'h80);
    pulse(8'h01);
    do_ack("R11 line0", 8'h40);
    eoi();
    pulse(8'h11);
    do_ack("R11 rotated line4 wins", 8'h44);
    eoi();
    do_ack("R11 line0 next", 8'h40);
    eoi();
    wr(2'd0, 8'h00);
    pulse(8'h08);
    do_ack("R11 line3", 8'h43);
    wr(2'd0, 8'hA0);
    pulse(8'h22);
    do_ack("R11 eoi-rotate line5 wins", 8'h45);
    eoi();
    chk("R11 line1 still pending", {7'd0, int_out}, 8'd1);
    do_ack("R11 line1", 8'h41);
    eoi();

    // R3/R6: 0x1A single, no option word, bit3 ignored
    wr(2'd0, 8'h1A);
    wr(2'd1, 8'h88);
    chk("R3 one data word suffices", {7'd0, int_out}, 8'd0);
    pulse(8'h40);
    repeat (2) @(negedge clk);
    chk("R6 line6 stays edge", {7'd0, int_out}, 8'd1);
    do_ack("R7 new base", 8'h8E);
    eoi();
    pulse(8'h04);
    @(negedge clk);
    chk("R6 line2 stays level", {7'd0, int_out}, 8'd0);

    // R3: 0x13 single with option word
    wr(2'd0, 8'h13);
    pulse(8'h20);
    wr(2'd1, 8'h20);
    chk("R3 waiting option word single", {7'd0, int_out}, 8'd1 - 8'd1);
    wr(2'd1, 8'hFF);
    chk("R3 ready after two words", {7'd0, int_out}, 8'd1);
    do_ack("R7 line5 base 0x20", 8'h25);
    eoi();

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule